// File: doc/BRIEF.md
# One-Time-Programmable Memory Image Burner

This block writes a complete byte image into a byte-wide one-time-programmable memory. A `start` pulse brings up the core rail and then the programming rail. The block then takes image bytes one per address, in ascending order, from a valid/ready source. For each address it presents the address and the byte, drives a timed active-low write pulse on chip enable, and reads the cell back at once. If the read-back does not match, it pulses again, up to a fixed limit per address.

After the last address is written, the programming rail goes off and the block makes a second, read-only pass at normal supply. The source replays the image for this pass so that every cell can be compared once more. The pass ends with the core rail going off.

A cell that stays wrong after the final permitted pulse, or a mismatch in the second pass, stops the run. The block then reports the offending address and still lowers the rails in their legal order. Rail voltages themselves are handled outside the block; it only drives the enables and a flag that marks when the rails sit at their programming levels.

Top module: `otp_burn_seq`

## Requirements
- R1: `prog_pwr_en` is never high while `core_pwr_en` is low. At power-up the core rail comes on at least `RAIL_CYC` cycles before the programming rail. At power-down it stays on at least `RAIL_CYC` cycles after the programming rail goes off.
- R2: Every write pulse holds `mem_ce_n` low, with `mem_oe_n` high, for exactly `CLK_MHZ*PULSE_US` consecutive cycles.
- R3: `mem_addr` and `mem_wdata` hold their values in the cycle before `mem_ce_n` falls for a write pulse, and they stay unchanged through the pulse.
- R4: Each write pulse is followed by a read window in which `mem_ce_n` and `mem_oe_n` are both low for `VERIFY_CYC` cycles. `mem_rdata` is compared in the last cycle of the window. A match moves to the next address. A mismatch triggers another pulse on the same address.
- R5: No address receives more than `MAX_PULSES` write pulses. A cell that first matches after exactly `MAX_PULSES` pulses counts as written.
- R6: If a cell still mismatches after the `MAX_PULSES`-th pulse, the run stops. `fail` goes high, `fail_addr` holds that address, higher addresses get no pulse, both rails shut down in legal order, and `done` rises.
- R7: Addresses are visited from 0 up to 2^AW-1. An image byte transfers when `img_valid` and `img_ready` are both high at a clock edge, exactly one byte per address in each pass. The source sends the image twice: once for writing and once for the final check.
- R8: After the writing pass the block reads every address again with `prog_pwr_en` and `prog_mode` low. A mismatch sets `fail` with `fail_addr` equal to that address and ends the run.
- R9: `prog_mode` is high only while both rails are enabled, and it is high throughout every write pulse.
- R10: `busy` is high from the cycle after `start` until `done` rises. `done` and `fail` then hold until the next accepted `start`. A clean run ends with `done` high and `fail` low.
- R11: After reset all outputs are inactive: `mem_ce_n` and `mem_oe_n` are high, and both rail enables, `prog_mode`, `img_ready`, `busy`, `done` and `fail` are low.
- R12: `start` is ignored while `busy` is high. A second pulse mid-run changes neither the pulse counts nor the number of bytes consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burn run (accepted only when idle) |
| img_valid | input | 1 | Image source has a byte |
| img_data | input | DW | Image byte for the current address |
| img_ready | output | 1 | Block takes the byte this cycle |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Data presented for writing |
| mem_rdata | input | DW | Data read back from the memory |
| mem_ce_n | output | 1 | Active-low chip enable (write pulse and read) |
| mem_oe_n | output | 1 | Active-low output enable (read) |
| core_pwr_en | output | 1 | Core supply enable |
| prog_pwr_en | output | 1 | Programming supply enable |
| prog_mode | output | 1 | Rails are settled at programming levels |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | Run ended on a bad cell |
| fail_addr | output | AW | Address of the bad cell |

## Verification
A read window can end at the same moment the pulse budget runs out. The block must then decide in one cycle between "matched on the last permitted pulse" and "failed". The bench provokes this with a memory model in which one cell needs exactly `MAX_PULSES` pulses, and in another run a cell that needs one more. The first case is judged correct if the run ends clean with that address showing `MAX_PULSES` pulses. The second is judged correct if `fail` names that address, the same count of pulses is recorded, and no higher address is touched.

// File: rtl/otp_burn_pkg.sv
package otp_burn_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CORE_UP,
        ST_PROG_UP,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_RECOV,
        ST_VERIFY,
        ST_PROG_DN,
        ST_FFETCH,
        ST_FREAD,
        ST_CORE_DN
    } burn_st_e;

    typedef struct packed {
        logic tmr_load;
        logic addr_clr;
        logic addr_inc;
        logic try_clr;
        logic try_inc;
        logic take;
        logic set_fail;
        logic set_done;
        logic clr_flags;
    } burn_ctl_t;

    function automatic int cyc_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/otp_burn_timer.sv
module otp_burn_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/otp_burn_retry.sv
module otp_burn_retry #(
    parameter int LIMIT = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int RW = $clog2(LIMIT + 1);
    logic [RW-1:0] tries;

    always_ff @(posedge clk) begin
        if (rst || clr) tries <= '0;
        else if (inc)   tries <= tries + 1'b1;
    end

    assign at_limit = (tries == RW'(LIMIT));
endmodule

// File: rtl/otp_burn_addr.sv
module otp_burn_addr #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic          last
);
    always_ff @(posedge clk) begin
        if (rst || clr) addr <= '0;
        else if (inc)   addr <= addr + 1'b1;
    end

    assign last = (addr == {AW{1'b1}});
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
    import otp_burn_pkg::*;
#(
    parameter int AW         = 20,
    parameter int DW         = 8,
    parameter int CLK_MHZ    = 250,
    parameter int PULSE_US   = 50,
    parameter int MAX_PULSES = 25,
    parameter int VERIFY_CYC = 3,
    parameter int RAIL_CYC   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          img_valid,
    input  logic [DW-1:0] img_data,
    output logic          img_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          core_pwr_en,
    output logic          prog_pwr_en,
    output logic          prog_mode,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr
);
    localparam int PULSE_CYC = CLK_MHZ * PULSE_US;
    localparam int TW        = $clog2(cyc_max3(PULSE_CYC, VERIFY_CYC, RAIL_CYC) + 1);
    localparam logic [TW-1:0] T_PULSE = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] T_VERIFY = TW'(VERIFY_CYC - 1);
    localparam logic [TW-1:0] T_RAIL = TW'(RAIL_CYC - 1);

    burn_st_e      state, nxt;
    burn_ctl_t     ctl;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero, at_limit, last;
    logic [DW-1:0] data_q;
    logic          done_q, fail_q;
    logic [AW-1:0] fail_addr_q;
    logic          match;

    otp_burn_timer #(.TW(TW)) tmr_i (
        .clk(clk), .rst(rst), .load(ctl.tmr_load), .load_val(tmr_val), .expired(tmr_zero)
    );

    otp_burn_retry #(.LIMIT(MAX_PULSES)) try_i (
        .clk(clk), .rst(rst), .clr(ctl.try_clr), .inc(ctl.try_inc), .at_limit(at_limit)
    );

    otp_burn_addr #(.AW(AW)) addr_i (
        .clk(clk), .rst(rst), .clr(ctl.addr_clr), .inc(ctl.addr_inc), .addr(mem_addr), .last(last)
    );

    assign match = (mem_rdata == data_q);

    always_comb begin
        nxt     = state;
        ctl     = '0;
        tmr_val = '0;
        case (state)
            ST_IDLE: if (start) begin
                nxt = ST_CORE_UP; ctl.tmr_load = 1'b1; tmr_val = T_RAIL;
                ctl.addr_clr = 1'b1; ctl.clr_flags = 1'b1;
            end
            ST_CORE_UP: if (tmr_zero) begin
                nxt = ST_PROG_UP; ctl.tmr_load = 1'b1; tmr_val = T_RAIL;
            end
            ST_PROG_UP: if (tmr_zero) nxt = ST_FETCH;
            ST_FETCH: if (img_valid) begin
                nxt = ST_SETUP; ctl.take = 1'b1; ctl.try_clr = 1'b1;
            end
            ST_SETUP: begin
                nxt = ST_PULSE; ctl.tmr_load = 1'b1; tmr_val = T_PULSE; ctl.try_inc = 1'b1;
            end
            ST_PULSE: if (tmr_zero) nxt = ST_RECOV;
            ST_RECOV: begin
                nxt = ST_VERIFY; ctl.tmr_load = 1'b1; tmr_val = T_VERIFY;
            end
            ST_VERIFY: if (tmr_zero) begin
                if (match && !last) begin
                    nxt = ST_FETCH; ctl.addr_inc = 1'b1;
                end else if (match || at_limit) begin
                    nxt = ST_PROG_DN; ctl.tmr_load = 1'b1; tmr_val = T_RAIL;
                    ctl.set_fail = !match; ctl.addr_clr = match;
                end else begin
                    nxt = ST_SETUP;
                end
            end
            ST_PROG_DN: if (tmr_zero) begin
                if (fail_q) begin
                    nxt = ST_CORE_DN; ctl.tmr_load = 1'b1; tmr_val = T_RAIL;
                end else begin
                    nxt = ST_FFETCH;
                end
            end
            ST_FFETCH: if (img_valid) begin
                nxt = ST_FREAD; ctl.take = 1'b1; ctl.tmr_load = 1'b1; tmr_val = T_VERIFY;
            end
            ST_FREAD: if (tmr_zero) begin
                if (match && !last) begin
                    nxt = ST_FFETCH; ctl.addr_inc = 1'b1;
                end else begin
                    nxt = ST_CORE_DN; ctl.tmr_load = 1'b1; tmr_val = T_RAIL;
                    ctl.set_fail = !match;
                end
            end
            ST_CORE_DN: if (tmr_zero) begin
                nxt = ST_IDLE; ctl.set_done = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            data_q      <= '0;
            done_q      <= 1'b0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
        end else begin
            state <= nxt;
            if (ctl.take)      data_q <= img_data;
            if (ctl.clr_flags) begin
                done_q <= 1'b0;
                fail_q <= 1'b0;
            end
            if (ctl.set_fail) begin
                fail_q      <= 1'b1;
                fail_addr_q <= mem_addr;
            end
            if (ctl.set_done)  done_q <= 1'b1;
        end
    end

    assign img_ready   = (state == ST_FETCH) || (state == ST_FFETCH);
    assign mem_wdata   = data_q;
    assign mem_ce_n    = !((state == ST_PULSE) || (state == ST_VERIFY) || (state == ST_FREAD));
    assign mem_oe_n    = !((state == ST_VERIFY) || (state == ST_FREAD));
    assign core_pwr_en = (state != ST_IDLE);
    assign prog_pwr_en = (state inside {ST_PROG_UP, ST_FETCH, ST_SETUP, ST_PULSE, ST_RECOV, ST_VERIFY});
    assign prog_mode   = (state inside {ST_FETCH, ST_SETUP, ST_PULSE, ST_RECOV, ST_VERIFY});
    assign busy        = (state != ST_IDLE);
    assign done        = done_q;
    assign fail        = fail_q;
    assign fail_addr   = fail_addr_q;
endmodule

// File: rtl/otp_burn_chk.sv
module otp_burn_chk #(
    parameter int AW        = 20,
    parameter int DW        = 8,
    parameter int PULSE_CYC = 12500
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          core_pwr_en,
    input logic          prog_pwr_en,
    input logic          prog_mode,
    input logic          busy,
    input logic          done
);
    logic [31:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)                       low_run <= '0;
        else if (!mem_ce_n && mem_oe_n) low_run <= low_run + 1;
        else                           low_run <= '0;
    end

    AST_RAIL_ORDER: assert property (@(posedge clk) disable iff (rst)
        prog_pwr_en |-> core_pwr_en);                                                // R1
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_ce_n) && $past(mem_oe_n)) |-> (low_run == 32'(PULSE_CYC)));       // R2
    AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_ce_n) && mem_oe_n) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R3
    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && mem_oe_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R3
    AST_PULSE_IN_MODE: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && mem_oe_n) |-> prog_mode);                                       // R9
    AST_MODE_RAILS: assert property (@(posedge clk) disable iff (rst)
        prog_mode |-> (prog_pwr_en && core_pwr_en));                                  // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                              // R10
endmodule

bind otp_burn_seq otp_burn_chk #(
    .AW(AW), .DW(DW), .PULSE_CYC(CLK_MHZ * PULSE_US)
) chk_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .core_pwr_en(core_pwr_en),
    .prog_pwr_en(prog_pwr_en), .prog_mode(prog_mode), .busy(busy), .done(done)
);

// File: tb/otp_burn_seq_tb_top.sv
module otp_burn_seq_tb_top;
    localparam int AW = 4, DW = 8, N = 16, PW = 5, VC = 3, RC = 3, MAXP = 25;
    localparam int LIMIT = 20000;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, img_valid = 1'b0;
    logic [DW-1:0] img_data = '0;
    logic img_ready, mem_ce_n, mem_oe_n, core_pwr_en, prog_pwr_en, prog_mode, busy, done, fail;
    logic [AW-1:0] mem_addr, fail_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    logic [DW-1:0] image [N];
    logic [DW-1:0] mem   [N];
    int hard [N];
    int pcount [N];
    int flaky = -1;
    int src_idx = 0;
    int rail_err, pw_err, vr_err, st_err, mode_err, fin_reads;
    int checks = 0, errors = 0;
    bit timed_out = 0;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    otp_burn_seq #(
        .AW(AW), .DW(DW), .CLK_MHZ(1), .PULSE_US(PW),
        .MAX_PULSES(MAXP), .VERIFY_CYC(VC), .RAIL_CYC(RC)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .img_valid(img_valid), .img_data(img_data),
        .img_ready(img_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .core_pwr_en(core_pwr_en),
        .prog_pwr_en(prog_pwr_en), .prog_mode(prog_mode), .busy(busy), .done(done),
        .fail(fail), .fail_addr(fail_addr)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // memory cell model and interface monitor
    initial begin
        int lo_len, rd_len, prev_prog, rd_prog;
        logic [AW-1:0] pa;
        logic [DW-1:0] pd;
        bit prev_ce;
        lo_len = 0; rd_len = 0; prev_prog = 0; rd_prog = 0; prev_ce = 1; pa = '0; pd = '0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (prev_ce && !mem_ce_n && mem_oe_n && (pa != mem_addr || pd != mem_wdata)) st_err++;
                if (!mem_ce_n && mem_oe_n) begin
                    if (!prog_mode) mode_err++;
                    lo_len++;
                end else if (lo_len > 0) begin
                    if (lo_len != PW) pw_err++;
                    pcount[mem_addr]++;
                    if (pcount[mem_addr] >= hard[mem_addr]) mem[mem_addr] = mem[mem_addr] & mem_wdata;
                    lo_len = 0;
                end
                if (!mem_ce_n && !mem_oe_n) begin
                    rd_len++;
                    rd_prog = prog_pwr_en;
                end else if (rd_len > 0) begin
                    if (rd_len != VC) vr_err++;
                    if (!rd_prog) fin_reads++;
                    rd_len = 0;
                end
                if (prog_pwr_en && !core_pwr_en) rail_err++;
                if (prev_prog && !prog_pwr_en && flaky >= 0) mem[flaky] = mem[flaky] ^ 8'h01;
            end
            prev_prog = prog_pwr_en;
            prev_ce = mem_ce_n;
            pa = mem_addr;
            pd = mem_wdata;
        end
    end

    // image source, replays the image for the second pass
    initial begin
        bit acc;
        acc = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                src_idx = 0; acc = 0; img_valid = 1'b0;
            end else begin
                if (acc) src_idx++;
                img_valid = (src_idx < 2 * N) && (($urandom % 4) != 0);
                img_data  = image[src_idx % N];
                acc = img_valid && img_ready;
            end
        end
    end

    function automatic int exp_pulses(input int a, input int fa);
        if (fa < 0 || a < fa) return hard[a];
        if (a == fa) return MAXP;
        return 0;
    endfunction

    task automatic run(input string name, input int hmax, input int hard_idx, input int hard_val,
                       input int fl, input bit mid_start);
        int fa, cyc, exp_reads, exp_src;
        fa = -1;
        for (int a = 0; a < N; a++) begin
            image[a] = 8'($urandom);
            if (image[a] == 8'hFF) image[a] = 8'hFE;
            hard[a] = 1 + int'($urandom % hmax);
            mem[a] = 8'hFF;
            pcount[a] = 0;
        end
        if (hard_idx >= 0) hard[hard_idx] = hard_val;
        for (int a = N - 1; a >= 0; a--) if (hard[a] > MAXP) fa = a;
        flaky = fl;
        rail_err = 0; pw_err = 0; vr_err = 0; st_err = 0; mode_err = 0; fin_reads = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11", {name, " ce_n after reset"}, mem_ce_n, 1);
        check("R11", {name, " oe_n/rails/ready after reset"},
              {mem_oe_n, core_pwr_en, prog_pwr_en, prog_mode, img_ready}, 5'b10000);
        check("R11", {name, " busy/done/fail after reset"}, {busy, done, fail}, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10", {name, " busy after start"}, busy, 1);
        if (mid_start) begin
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            timed_out = 1;
            check("R10", {name, " watchdog, run never finished"}, 0, 1);
            return;
        end
        repeat (2) @(negedge clk);
        exp_reads = (fa >= 0) ? 0 : ((fl >= 0) ? fl + 1 : N);
        exp_src   = (fa >= 0) ? fa + 1 : ((fl >= 0) ? N + fl + 1 : 2 * N);
        check("R1", {name, " rail order violations"}, rail_err, 0);
        check("R1", {name, " rails off at end"}, {core_pwr_en, prog_pwr_en}, 0);
        check("R2", {name, " pulse width errors"}, pw_err, 0);
        check("R3", {name, " addr/data unstable at pulse start"}, st_err, 0);
        check("R4", {name, " read window length errors"}, vr_err, 0);
        check("R9", {name, " pulses outside prog_mode"}, mode_err, 0);
        check("R10", {name, " done held, busy low"}, {done, busy}, 2'b10);
        check("R8", {name, " final-pass reads with prog rail off"}, fin_reads, exp_reads);
        if (mid_start) check("R12", {name, " bytes consumed with mid-run start"}, src_idx, exp_src);
        else           check("R7", {name, " bytes consumed"}, src_idx, exp_src);
        for (int a = 0; a < N; a++) begin
            check((fa >= 0 && a == fa) ? "R6" : (hard[a] == MAXP ? "R5" : "R4"),
                  $sformatf("%s pulses at addr %0d", name, a), pcount[a], exp_pulses(a, fa));
            check((fa >= 0 && a > fa) ? "R6" : "R7", $sformatf("%s cell %0d", name, a), int'(mem[a]),
                  (fa >= 0 && a >= fa) ? 8'hFF : ((a == fl) ? int'(image[a] ^ 8'h01) : int'(image[a])));
        end
        if (fa >= 0) begin
            check("R6", {name, " fail flag"}, fail, 1);
            check("R6", {name, " fail address"}, fail_addr, fa);
        end else if (fl >= 0) begin
            check("R8", {name, " fail flag"}, fail, 1);
            check("R8", {name, " fail address"}, fail_addr, fl);
        end else begin
            check(hard_idx >= 0 ? "R5" : "R10", {name, " clean finish"}, fail, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240613));
        run("random",        4, -1, 0,        -1, 1'b1);
        if (!timed_out) run("limit_pass",    3,  7, MAXP,     -1, 1'b0);
        if (!timed_out) run("limit_fail",    3,  5, MAXP + 1, -1, 1'b0);
        if (!timed_out) run("final_mismatch", 3, -1, 0,        9, 1'b0);
        if (!timed_out) run("random_hard",   8, -1, 0,        -1, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule